// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block gathers a small set of condition inputs, such as a headset being present or a supply having crossed a threshold, and produces one active-low interrupt pin. Each input is synchronised to the local clock and appears in a status/event register in two forms. The live status bit tracks the condition as it is now. The sticky event bit records that the condition changed. A mask register decides which of these bits may pull the interrupt pin. A per-source enable can send a source's live level to the pin in place of its latched event.

Software reads the status/event register through the `regValue` port. The register port strobes `rdClr` on a read, and that strobe clears every latched event. A power-on reset loads the defaults, raises the power-on event bit and unmasks it, so the pin asserts as soon as the part comes out of reset. A mode input selects push-pull drive or open-drain drive for the pin.

Top module: `irq_status_ctrl`

## Requirements
- R1: While and right after reset, `regValue` equals 1: bit 0, the power-on event, is set and every other bit is clear. The mask register resets to having only bit 0 set, so the pin is active at once.
- R2: The bit at position 1+i of `regValue` shows the live level of `statusIn[i]` two clock cycles later, through a two-stage synchroniser.
- R3: The bit at position 1+NUM_SRC+i of `regValue` is a sticky event bit. A rising transition of synchronised source i sets it. A falling transition also sets it, unless bit i of RISE_ONLY_MASK is 1. Source 1 is rising-only by default. The bit stays set after the input returns to its old level.
- R4: A one-cycle `rdClr` pulse clears every event bit, including the power-on bit 0. Live status bits are not affected.
- R5: When a transition sets an event bit in the same cycle as `rdClr`, the set wins and the bit ends up 1.
- R6: A bit can activate the interrupt only when the mask bit at the same position is 1. With the mask at its reset value and the power-on event cleared, new events leave the pin inactive.
- R7: When `statusEn[i]` is 1, the pin term for source i is its live status ANDed with mask bit 1+i, and its event bit is ignored for the pin. When `statusEn[i]` is 0, the term is the event bit ANDed with mask bit 1+NUM_SRC+i.
- R8: `maskWr` loads `maskData` into the mask register on a clock edge. Mask bit positions match the `regValue` layout.
- R9: When `openDrain`=0 (push-pull), `irqOe`=1 and `irqOut` is the inverse of the interrupt state. When `openDrain`=1, `irqOut`=0 and `irqOe` is 1 only while the interrupt is active.
- R10: The pin drive is registered. It reflects the masked interrupt state one clock edge after that state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| statusIn | input | NUM_SRC | Raw condition levels, asynchronous |
| statusEn | input | NUM_SRC | Per source: 1 routes the live level to the pin, 0 routes the event bit |
| maskWr | input | 1 | Mask register write strobe |
| maskData | input | 2*NUM_SRC+1 | Mask write data |
| rdClr | input | 1 | Read strobe; clears the event bits |
| openDrain | input | 1 | 1 selects open-drain drive, 0 selects push-pull drive |
| regValue | output | 2*NUM_SRC+1 | {events, live status, power-on event} |
| irqOut | output | 1 | Interrupt pin drive value, active low |
| irqOe | output | 1 | Interrupt pin output enable |

## Verification
The hardest case to reach is a read-clear that lands on the exact cycle in which a new edge sets an event. The bench counts the synchroniser and edge-detector registers from a negedge input change and raises `rdClr` only for the edge at which the event is stored. Pin routing is checked by sweeping every mask value against every enable pattern, in both drive modes. This sweep runs with the register holding a live level without an event on one source and an event without a live level on another. That difference separates the live-level path from the event path.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef struct packed {
    logic clrEvents;
    logic loadMask;
  } intcStrb_t;
endpackage

// File: rtl/intc_src_cell.sv
module intc_src_cell #(
  parameter int SYNC_STAGES = 2,
  parameter bit RISE_ONLY   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rawIn,
  output logic liveLvl,
  output logic edgeHit
);
  logic [SYNC_STAGES-1:0] syncPipe;
  logic prevLvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncPipe <= '0;
      prevLvl  <= 1'b0;
    end else begin
      syncPipe <= {syncPipe[SYNC_STAGES-2:0], rawIn};
      prevLvl  <= syncPipe[SYNC_STAGES-1];
    end
  end

  assign liveLvl = syncPipe[SYNC_STAGES-1];

  generate
    if (RISE_ONLY) begin : g_rise
      assign edgeHit = liveLvl & ~prevLvl;
    end else begin : g_both
      assign edgeHit = liveLvl ^ prevLvl;
    end
  endgenerate
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_SRC-1:0] RISE_ONLY_MASK = '0,
  localparam int REG_W = 2*NUM_SRC + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  intcStrb_t          strb,
  input  logic [NUM_SRC-1:0] statusIn,
  input  logic [NUM_SRC-1:0] statusEn,
  input  logic [REG_W-1:0]   maskData,
  output logic [REG_W-1:0]   regValue,
  output logic [REG_W-1:0]   maskQ,
  output logic               irqAct
);
  localparam int LIVE_LSB = 1;
  localparam int EV_LSB   = 1 + NUM_SRC;

  logic [NUM_SRC-1:0] liveVec;
  logic [NUM_SRC-1:0] edgeVec;
  logic [NUM_SRC-1:0] evBits;
  logic               porEv;

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      intc_src_cell #(
        .SYNC_STAGES(SYNC_STAGES),
        .RISE_ONLY  (RISE_ONLY_MASK[s])
      ) u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .rawIn  (statusIn[s]),
        .liveLvl(liveVec[s]),
        .edgeHit(edgeVec[s])
      );
    end
  endgenerate

  // Event capture: a new edge has priority over a read-clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      porEv  <= 1'b1;
      evBits <= '0;
    end else begin
      if (strb.clrEvents) porEv <= 1'b0;
      evBits <= (strb.clrEvents ? '0 : evBits) | edgeVec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maskQ <= REG_W'(1);
    end else if (strb.loadMask) begin
      maskQ <= maskData;
    end
  end

  assign regValue = {evBits, liveVec, porEv};

  always_comb begin
    irqAct = porEv & maskQ[0];
    for (int s = 0; s < NUM_SRC; s++) begin
      if (statusEn[s]) irqAct = irqAct | (liveVec[s] & maskQ[LIVE_LSB+s]);
      else             irqAct = irqAct | (evBits[s]  & maskQ[EV_LSB+s]);
    end
  end
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rdClr,
  input  logic      maskWr,
  input  logic      irqAct,
  input  logic      openDrain,
  output intcStrb_t strb,
  output logic      irqOut,
  output logic      irqOe
);
  logic pinAct;

  always_comb begin
    strb.clrEvents = rdClr;
    strb.loadMask  = maskWr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pinAct <= 1'b1;
    else        pinAct <= irqAct;
  end

  assign irqOut = openDrain ? 1'b0 : ~pinAct;
  assign irqOe  = openDrain ? pinAct : 1'b1;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_SRC-1:0] RISE_ONLY_MASK = 3'b010,
  localparam int REG_W = 2*NUM_SRC + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] statusIn,
  input  logic [NUM_SRC-1:0] statusEn,
  input  logic               maskWr,
  input  logic [REG_W-1:0]   maskData,
  input  logic               rdClr,
  input  logic               openDrain,
  output logic [REG_W-1:0]   regValue,
  output logic               irqOut,
  output logic               irqOe
);
  intcStrb_t          strb;
  logic [REG_W-1:0]   maskQ;
  logic               irqAct;

  intc_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdClr    (rdClr),
    .maskWr   (maskWr),
    .irqAct   (irqAct),
    .openDrain(openDrain),
    .strb     (strb),
    .irqOut   (irqOut),
    .irqOe    (irqOe)
  );

  intc_datapath #(
    .NUM_SRC       (NUM_SRC),
    .SYNC_STAGES   (SYNC_STAGES),
    .RISE_ONLY_MASK(RISE_ONLY_MASK)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .statusIn(statusIn),
    .statusEn(statusEn),
    .maskData(maskData),
    .regValue(regValue),
    .maskQ   (maskQ),
    .irqAct  (irqAct)
  );
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int NUM_SRC = 3,
  localparam int REG_W = 2*NUM_SRC + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rdClr,
  input logic [NUM_SRC-1:0] statusIn,
  input logic [REG_W-1:0]   regValue,
  input logic [REG_W-1:0]   maskQ,
  input logic               irqAct,
  input logic               openDrain,
  input logic               irqOut,
  input logic               irqOe
);
  logic [1:0] sinceRst;
  logic       pinOn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sinceRst <= 2'd0;
    else if (sinceRst != 3)  sinceRst <= sinceRst + 2'd1;
  end

  assign pinOn = openDrain ? irqOe : ~irqOut;

  AST_POR_EVENT: assert property (@(posedge clk) !rst_n |=> regValue[0]); // R1
  AST_LIVE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (sinceRst >= 2) |-> (regValue[NUM_SRC:1] == $past(statusIn, 2))); // R2
  AST_POR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rdClr |=> !regValue[0]); // R4
  AST_ACT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irqAct |-> (|(maskQ & regValue))); // R6
  AST_PIN_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (sinceRst != 0) |-> (pinOn == $past(irqAct))); // R10

  generate
    for (genvar e = 0; e < NUM_SRC; e++) begin : g_ev
      AST_EVENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdClr && regValue[1+NUM_SRC+e]) |=> regValue[1+NUM_SRC+e]); // R3
    end
  endgenerate
endmodule

bind irq_status_ctrl intc_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rdClr    (rdClr),
  .statusIn (statusIn),
  .regValue (regValue),
  .maskQ    (maskQ),
  .irqAct   (irqAct),
  .openDrain(openDrain),
  .irqOut   (irqOut),
  .irqOe    (irqOe)
);

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
  localparam int N = 3;
  localparam int W = 2*N + 1;
  localparam logic [N-1:0] RISE_ONLY = 3'b010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] statusIn = '0;
  logic [N-1:0] statusEn = '0;
  logic maskWr = 1'b0;
  logic [W-1:0] maskData = '0;
  logic rdClr = 1'b0;
  logic openDrain = 1'b0;
  logic [W-1:0] regValue;
  logic irqOut, irqOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_status_ctrl dut (
    .clk(clk), .rst_n(rst_n), .statusIn(statusIn), .statusEn(statusEn),
    .maskWr(maskWr), .maskData(maskData), .rdClr(rdClr), .openDrain(openDrain),
    .regValue(regValue), .irqOut(irqOut), .irqOe(irqOe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] pinExp(input logic act, input logic od);
    return od ? {1'b0, act} : {~act, 1'b1};
  endfunction

  task automatic pulseClr();
    rdClr = 1'b1; tick(1); rdClr = 1'b0;
  endtask

  task automatic writeMask(input logic [W-1:0] m);
    maskData = m; maskWr = 1'b1; tick(1); maskWr = 1'b0;
  endtask

  initial begin
    #(4*200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] live, ev;
    tick(3);
    check("R1 reset value", 32'(regValue), 32'd1);
    check("R1 pin in reset", 32'({irqOut, irqOe}), 32'(pinExp(1'b1, 1'b0)));
    rst_n = 1'b1;
    check("R1 value after release", 32'(regValue), 32'd1);
    tick(2);
    check("R1 pin active push-pull", 32'({irqOut, irqOe}), 32'(pinExp(1'b1, 1'b0)));
    openDrain = 1'b1; tick(1);
    check("R9 open-drain active", 32'({irqOut, irqOe}), 32'(pinExp(1'b1, 1'b1)));
    openDrain = 1'b0;
    pulseClr(); tick(2);
    check("R4 power-on event cleared", 32'(regValue), 32'd0);
    check("R9 push-pull idle", 32'({irqOut, irqOe}), 32'(pinExp(1'b0, 1'b0)));

    // R2 R3 R4 R6 per-source edges
    for (int i = 0; i < N; i++) begin
      statusIn[i] = 1'b1; tick(5);
      check("R2 R3 rise sets live and event", 32'(regValue),
            32'((1 << (1+i)) | (1 << (1+N+i))));
      check("R6 masked event keeps pin idle", 32'({irqOut, irqOe}), 32'(pinExp(1'b0, 1'b0)));
      pulseClr(); tick(3);
      check("R4 clear keeps live status", 32'(regValue), 32'(1 << (1+i)));
      statusIn[i] = 1'b0; tick(5);
      check("R3 falling edge policy", 32'(regValue),
            RISE_ONLY[i] ? 32'd0 : 32'(1 << (1+N+i)));
      pulseClr(); tick(3);
      check("R4 all cleared", 32'(regValue), 32'd0);
    end

    // R5: clear strobe on the edge that stores the event
    statusIn[0] = 1'b1;
    tick(1); tick(1);
    rdClr = 1'b1; tick(1); rdClr = 1'b0;
    check("R5 set wins over clear", 32'(regValue[1+N]), 32'd1);
    tick(2);
    check("R5 event still held", 32'(regValue[1+N]), 32'd1);
    statusIn[0] = 1'b0; tick(5); pulseClr(); tick(3);
    check("R4 cleanup", 32'(regValue), 32'd0);

    // Build live=001, events=100
    statusIn = 3'b111; tick(5); pulseClr(); tick(2);
    statusIn = 3'b001; tick(5);
    live = 3'b001; ev = 3'b100;
    check("R2 R3 sweep state", 32'(regValue), 32'd66);

    // R6 R7 R8 R9: sweep every mask and enable pattern
    for (int m = 0; m < (1 << W); m++) begin
      for (int en = 0; en < (1 << N); en++) begin
        logic act;
        logic [W-1:0] mv;
        logic od;
        mv = W'(m);
        od = 1'((m + en) % 2);
        statusEn = N'(en);
        openDrain = od;
        writeMask(mv);
        tick(2);
        act = 1'b0;
        for (int s = 0; s < N; s++) begin
          if (en[s]) act = act | (mv[1+s] & live[s]);
          else       act = act | (mv[1+N+s] & ev[s]);
        end
        check("R6 R7 R8 R9 mask sweep", 32'({irqOut, irqOe}), 32'(pinExp(act, od)));
      end
    end

    // Second power-on reset, then R10 latency
    statusIn = '0; statusEn = '0; openDrain = 1'b0;
    rst_n = 1'b0; tick(2); rst_n = 1'b1;
    check("R1 value after second reset", 32'(regValue), 32'd1);
    check("R1 pin after second reset", 32'({irqOut, irqOe}), 32'(pinExp(1'b1, 1'b0)));
    writeMask('0);
    check("R10 pin one edge after mask load", 32'({irqOut, irqOe}), 32'(pinExp(1'b1, 1'b0)));
    tick(1);
    check("R10 R8 pin idle when power-on bit masked", 32'({irqOut, irqOe}), 32'(pinExp(1'b0, 1'b0)));
    check("R8 event still stored", 32'(regValue), 32'd1);
    writeMask(W'(1)); tick(1);
    check("R1 R8 pin back on", 32'({irqOut, irqOe}), 32'(pinExp(1'b1, 1'b0)));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule